// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a synchronous host and an external 512K x 16 asynchronous static RAM. The host hands over one request at a time: a 19-bit word address, a read or write flag, two byte-lane enables and, for a write, 16 bits of data. The controller turns that request into a sequence of active-low pin levels. The pins are chip select, output enable, write strobe and the upper and lower lane selects. It holds each phase for a whole number of clock cycles, so that the memory's nanosecond minimums are met.

Each wait count is computed during elaboration from a clock-period parameter and a speed-grade parameter (55 or 70 ns), rounded up to whole cycles. The shared data bus appears as a separate output word, a drive-enable and an input word, so the pad itself stays outside the block. A read finishes with a one-cycle response pulse that carries the captured word, with any unselected byte lane forced to zero. Between requests the memory is left deselected, in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, memCeN, memOeN, memWeN, memUbN and memLbN are all 1, memDqOe is 0 and reqReady is 1.
- R2: A read drives memCeN=0, memOeN=0 and memWeN=1 for exactly ceil(access/period) cycles (6 at 10 ns and the 55 ns grade). reqByteEn bit 0 drives memLbN low (bits 7:0) and bit 1 drives memUbN low (bits 15:8), each inverted from its enable bit.
- R3: One cycle after the last read cycle, rspValid is 1 for exactly one cycle. rspData holds memDqIn as sampled in that last read cycle, with the bits of unselected lanes zeroed.
- R4: A write drives memCeN=0, memWeN=0 and memOeN=1, with the lane selects as in R2, for max(ceil(strobe/period), ceil(cycle/period)-1) cycles (5 by default). memDqOe is 1 and memDqOut equals the request data for all of those cycles.
- R5: memAddr takes the request address in the first cycle of the access. It never changes between two consecutive cycles in which memCeN is 0.
- R6: memDqOe is 1 only while memOeN is 1, and memWeN and memOeN are never 0 together.
- R7: When a write follows a read, memOeN stays 1 for at least 1+ceil(20 ns/period) cycles (3 by default) before memDqOe rises. This takes the form of ceil(20 ns/period) extra deselected cycles, with reqReady 0, after the accepting cycle.
- R8: reqReady is 1 only in an idle cycle. A request is taken when reqValid and reqReady are both 1, and its first active cycle (or turnaround cycle) is the very next cycle. Back-to-back requests are separated only by that single idle cycle.
- R9: A request with both byte enables 0 keeps memUbN and memLbN at 1 for its whole duration, so the memory stays deselected. Such a read returns rspData of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 19 | Word address |
| reqByteEn | input | 2 | Lane enables, bit 1 upper, bit 0 lower |
| reqWdata | input | 16 | Write data |
| rspValid | output | 1 | One-cycle read response pulse |
| rspData | output | 16 | Read data, unselected lanes zero |
| memAddr | output | 19 | Address pins |
| memDqOut | output | 16 | Data to drive onto the shared bus |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 16 | Data seen on the shared bus |
| memCeN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memUbN | output | 1 | Upper lane select, active low |
| memLbN | output | 1 | Lower lane select, active low |

## Verification
The assertions assume that memDqIn is stable across each read window and that the host holds its request fields steady while reqValid waits for reqReady. The bench respects both. Its memory model returns the stored word for as long as select, output enable and high write strobe stay in place, and shows a fixed filler pattern otherwise. Requests change only on falling clock edges, and are held until the accepting cycle.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  // Strobes from sequencing to the datapath. laneOn and drive describe the
  // cycle that follows the current clock edge; takeReq and capture act on it.
  typedef struct packed {
    logic takeReq;
    logic capture;
    logic laneOn;
    logic drive;
  } dpStrobe_t;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int WE_CYC   = 5,
  parameter int TURN_CYC = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output logic      ceN,
  output logic      oeN,
  output logic      weN,
  output dpStrobe_t strobe
);

  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WE_CYC), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST   = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_TURN, S_RD, S_WR} seqState_t;

  seqState_t state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic prevRead, prevReadNext;

  always_comb begin
    stateNext    = state;
    cntNext      = cnt + 1'b1;
    prevReadNext = prevRead;
    unique case (state)
      S_IDLE: begin
        cntNext = '0;
        if (reqValid) begin
          if (reqWrite) stateNext = prevRead ? S_TURN : S_WR;
          else          stateNext = S_RD;
        end
      end
      S_TURN: if (cnt == TURN_LAST) begin stateNext = S_WR; cntNext = '0; end
      S_RD:   if (cnt == RD_LAST)   begin stateNext = S_IDLE; cntNext = '0; end
      S_WR:   if (cnt == WE_LAST)   begin stateNext = S_IDLE; cntNext = '0; end
      default: begin stateNext = S_IDLE; cntNext = '0; end
    endcase
    if (stateNext == S_RD) prevReadNext = 1'b1;
    if (stateNext == S_WR) prevReadNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      cnt      <= '0;
      prevRead <= 1'b0;
      ceN      <= 1'b1;
      oeN      <= 1'b1;
      weN      <= 1'b1;
    end else begin
      state    <= stateNext;
      cnt      <= cntNext;
      prevRead <= prevReadNext;
      ceN      <= !((stateNext == S_RD) || (stateNext == S_WR));
      oeN      <= !(stateNext == S_RD);
      weN      <= !(stateNext == S_WR);
    end
  end

  assign reqReady       = (state == S_IDLE);
  assign strobe.takeReq = (state == S_IDLE) && reqValid;
  assign strobe.capture = (state == S_RD) && (cnt == RD_LAST);
  assign strobe.laneOn  = (stateNext == S_RD) || (stateNext == S_WR);
  assign strobe.drive   = (stateNext == S_WR);

  // Pulse-width observers for the pin checks below.
  logic [CNT_W:0] oeLowRun, weLowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      oeLowRun <= '0;
      weLowRun <= '0;
    end else begin
      oeLowRun <= oeN ? '0 : ((oeLowRun == (CNT_W+1)'(MAX_CYC)) ? oeLowRun : oeLowRun + 1'b1);
      weLowRun <= weN ? '0 : ((weLowRun == (CNT_W+1)'(MAX_CYC)) ? weLowRun : weLowRun + 1'b1);
    end
  end

  p_read_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(oeN) |-> (oeLowRun == (CNT_W+1)'(RD_CYC)));

  p_strobe_window_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> (weLowRun == (CNT_W+1)'(WE_CYC)));

  p_select_during_strobe_r4: assert property (@(posedge clk) disable iff (!rstN)
    !weN |-> !ceN);

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [LANES-1:0]  laneN,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  localparam int LANE_W = DATA_W / LANES;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ, beSel;
  logic [DATA_W-1:0] laneMask;

  assign beSel = strobe.takeReq ? reqByteEn : beQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign laneMask[g*LANE_W +: LANE_W] = {LANE_W{beQ[g]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      beQ      <= '0;
      laneN    <= '1;
      memDqOe  <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strobe.takeReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqByteEn;
      end
      laneN    <= strobe.laneOn ? ~beSel : '1;
      memDqOe  <= strobe.drive;
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= memDqIn & laneMask;
    end
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;

  p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_rsp_lanes_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspData & ~laneMask) == '0));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sramc_pkg::*;
#(
  parameter int CLK_PERIOD_NS  = 10,
  parameter int SPEED_GRADE_NS = 55,
  parameter int ADDR_W         = 19,
  parameter int DATA_W         = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqByteEn,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memUbN,
  output logic              memLbN
);

  localparam bit SLOW      = (SPEED_GRADE_NS >= 70);
  localparam int ACCESS_NS = SLOW ? 70 : 55;
  localparam int STROBE_NS = SLOW ? 60 : 45;
  localparam int CYCLE_NS  = SLOW ? 70 : 55;
  localparam int FLOAT_NS  = 20;
  localparam int RD_CYC    = ceilDiv(ACCESS_NS, CLK_PERIOD_NS);
  localparam int WE_CYC    = maxOf(maxOf(ceilDiv(STROBE_NS, CLK_PERIOD_NS),
                                         ceilDiv(CYCLE_NS, CLK_PERIOD_NS) - 1), 1);
  localparam int TURN_CYC  = maxOf(ceilDiv(FLOAT_NS, CLK_PERIOD_NS), 1);
  localparam int LANES     = 2;

  dpStrobe_t strobe;
  logic [LANES-1:0] laneN;

  sramc_ctrl #(
    .RD_CYC(RD_CYC), .WE_CYC(WE_CYC), .TURN_CYC(TURN_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .ceN(memCeN), .oeN(memOeN), .weN(memWeN),
    .strobe(strobe)
  );

  sramc_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqByteEn(reqByteEn), .memDqIn(memDqIn),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .laneN(laneN), .rspValid(rspValid), .rspData(rspData)
  );

  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];

  // Cycles in a row with output enable high, saturating.
  localparam int GAP_W = $clog2(TURN_CYC + 2);
  logic [GAP_W-1:0] oeHighRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) oeHighRun <= GAP_W'(TURN_CYC + 1);
    else if (!memOeN) oeHighRun <= '0;
    else if (oeHighRun != GAP_W'(TURN_CYC + 1)) oeHighRun <= oeHighRun + 1'b1;
  end

  p_standby_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memUbN && memLbN && memWeN && memOeN && !memDqOe));

  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  p_strobe_oe_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(!memWeN && !memOeN));

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (oeHighRun == GAP_W'(TURN_CYC + 1)));

  p_ready_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);

endmodule

// File: tb/tb_sram_async_ctrl.sv
module tb_sram_async_ctrl;

  localparam int PERIOD_NS = 10;
  localparam int RD_N   = (55 + PERIOD_NS - 1) / PERIOD_NS;
  localparam int WE_N   = ((45 + PERIOD_NS - 1) / PERIOD_NS > (55 + PERIOD_NS - 1) / PERIOD_NS - 1)
                          ? (45 + PERIOD_NS - 1) / PERIOD_NS : (55 + PERIOD_NS - 1) / PERIOD_NS - 1;
  localparam int TURN_N = (20 + PERIOD_NS - 1) / PERIOD_NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [1:0]  reqByteEn = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, rspValid, memDqOe, memCeN, memOeN, memWeN, memUbN, memLbN;
  logic [15:0] rspData, memDqOut, memDqIn;
  logic [18:0] memAddr;

  always #5 clk = ~clk;

  sram_async_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqByteEn(reqByteEn),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memUbN(memUbN), .memLbN(memLbN)
  );

  // Behavioural memory: 64 words indexed by the low address bits.
  logic [15:0] memArr [64];
  initial for (int i = 0; i < 64; i++) memArr[i] = 16'h0;

  always @* begin
    if (!memCeN && !memOeN && memWeN) begin
      memDqIn[7:0]  = !memLbN ? memArr[memAddr[5:0]][7:0]  : 8'h5A;
      memDqIn[15:8] = !memUbN ? memArr[memAddr[5:0]][15:8] : 8'hC3;
    end else begin
      memDqIn = 16'hA5A5;
    end
  end

  // Expected-cycle queue: one entry per active cycle of an accepted request.
  typedef struct {
    logic [4:0]  pins;   // {ceN, oeN, weN, ubN, lbN}
    logic        dqOe;
    logic [18:0] addr;
    logic [15:0] dout;
    logic [1:0]  be;
    int          kind;   // 0 idle, 1 turn, 2 read, 3 write, 4 no-lane
    logic        lastRd;
  } frame_t;

  frame_t fq[$];
  frame_t cur;
  bit   mPrevRead = 0;
  bit   rspExp = 0;
  logic [15:0] rspDataExp = '0;
  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  function automatic string tagOf(input int k);
    case (k)
      0: return "R1";
      1: return "R7";
      2: return "R2";
      3: return "R4";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [15:0] laneMaskOf(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [18:0] act, input logic [18:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic void pushAccess(input logic wr, input logic [18:0] a,
                                     input logic [1:0] be, input logic [15:0] d);
    frame_t f;
    f.addr = a; f.dout = d; f.be = be; f.lastRd = 1'b0;
    if (!wr) begin
      for (int i = 0; i < RD_N; i++) begin
        f.pins = {1'b0, 1'b0, 1'b1, ~be[1], ~be[0]};
        f.dqOe = 1'b0; f.kind = (be == 2'b00) ? 4 : 2;
        f.lastRd = (i == RD_N - 1);
        fq.push_back(f);
      end
      mPrevRead = 1;
    end else begin
      if (mPrevRead) begin
        for (int i = 0; i < TURN_N; i++) begin
          f.pins = 5'b11111; f.dqOe = 1'b0; f.kind = 1;
          fq.push_back(f);
        end
      end
      for (int i = 0; i < WE_N; i++) begin
        f.pins = {1'b0, 1'b1, 1'b0, ~be[1], ~be[0]};
        f.dqOe = 1'b1; f.kind = (be == 2'b00) ? 4 : 3;
        fq.push_back(f);
      end
      mPrevRead = 0;
    end
  endfunction

  // Reference model and memory update, advanced on every rising edge.
  always @(posedge clk) begin
    if (rstN && !done) begin
      cycles++;
      if (!memCeN && !memWeN) begin
        if (!memLbN) memArr[memAddr[5:0]][7:0]  = memDqOut[7:0];
        if (!memUbN) memArr[memAddr[5:0]][15:8] = memDqOut[15:8];
      end
      rspExp = 0;
      if (fq.size() != 0) begin
        frame_t p;
        p = fq.pop_front();
        if (p.lastRd) begin
          rspExp = 1;
          rspDataExp = memArr[p.addr[5:0]] & laneMaskOf(p.be);
        end
      end else if (reqValid) begin
        pushAccess(reqWrite, reqAddr, reqByteEn, reqWdata);
      end
    end
  end

  // Comparison away from the active edge.
  always @(negedge clk) begin
    if (rstN && !done) begin
      if (fq.size() != 0) cur = fq[0];
      else begin
        cur.pins = 5'b11111; cur.dqOe = 1'b0; cur.kind = 0;
        cur.addr = '0; cur.dout = '0; cur.be = '0; cur.lastRd = 1'b0;
      end
      check({memCeN, memOeN, memWeN, memUbN, memLbN} == cur.pins, tagOf(cur.kind), "pins",
            19'({memCeN, memOeN, memWeN, memUbN, memLbN}), 19'(cur.pins));
      check(memDqOe == cur.dqOe, (cur.kind == 0) ? "R6" : tagOf(cur.kind), "drive",
            19'(memDqOe), 19'(cur.dqOe));
      check(reqReady == (fq.size() == 0), "R8", "ready", 19'(reqReady), 19'(fq.size() == 0));
      if (!cur.pins[4]) check(memAddr == cur.addr, "R5", "addr", memAddr, cur.addr);
      if (cur.dqOe) check(memDqOut == cur.dout, "R4", "wdata", 19'(memDqOut), 19'(cur.dout));
      check(rspValid == rspExp, "R3", "rspValid", 19'(rspValid), 19'(rspExp));
      if (rspExp) check(rspData == rspDataExp, "R3", "rspData", 19'(rspData), 19'(rspDataExp));
    end
  end

  task automatic doReq(input logic wr, input logic [18:0] a, input logic [1:0] be,
                       input logic [15:0] d);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqByteEn = be; reqWdata = d;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Watchdog.
  initial begin
    #(200000 * PERIOD_NS);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen while reset is still applied.
    check({memCeN, memOeN, memWeN, memUbN, memLbN} == 5'b11111, "R1", "reset pins",
          19'({memCeN, memOeN, memWeN, memUbN, memLbN}), 19'h1f);
    check(memDqOe == 1'b0 && rspValid == 1'b0, "R1", "reset drive",
          19'({memDqOe, rspValid}), 19'h0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    doReq(1'b1, 19'h00001, 2'b11, 16'hBEEF);  // R4 word write
    doReq(1'b1, 19'h00002, 2'b01, 16'h1234);  // R4 lower lane
    doReq(1'b1, 19'h00003, 2'b10, 16'h5678);  // R4 upper lane, write after write
    doReq(1'b0, 19'h00001, 2'b11, 16'h0);     // R2/R3 word read
    doReq(1'b0, 19'h00002, 2'b01, 16'h0);     // R3 lower only
    doReq(1'b0, 19'h00003, 2'b10, 16'h0);     // R3 upper only
    doReq(1'b1, 19'h7FFC5, 2'b11, 16'hCAFE);  // R7 write after read, top address
    doReq(1'b0, 19'h7FFC5, 2'b11, 16'h0);
    doReq(1'b0, 19'h00001, 2'b00, 16'h0);     // R9 read with no lanes
    doReq(1'b1, 19'h00001, 2'b00, 16'hFFFF);  // R9 write with no lanes (after read: R7)
    doReq(1'b0, 19'h00001, 2'b11, 16'h0);     // R9 word untouched
    repeat (4) @(negedge clk);
    for (int n = 0; n < 60; n++) begin
      doReq(1'($urandom), 19'($urandom), 2'($urandom), 16'($urandom));
      if (n % 7 == 0) repeat (2) @(negedge clk);
    end
    while (fq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finishRun();
  end

endmodule